// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a memory read or write burst. A start strobe loads the starting column together with the mode fields. From the next cycle the block presents one column per cycle, a valid flag, and a flag that marks the final beat.

The beats follow one of two orders. Sequential order counts upward and wraps inside a block aligned to the burst length. Interleaved order XORs the starting column with the beat number. A full-page length is available only in sequential order. It walks all 256 columns, wraps from 255 to 0, and keeps running until it is stopped or replaced.

A terminate strobe ends the burst. A new start strobe replaces the current burst on any cycle. A write-mode bit makes every write a single access, while reads keep the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `beat_valid` and `beat_last` are 0.
- R2: A cycle with `start` high makes `beat_valid` 1 in the next cycle, with `col_addr` equal to the `start_col` sampled with `start`.
- R3: `len_code` sets the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. `beat_last` is 1 only on the final beat, and `beat_valid` falls in the cycle after it unless a new start arrives.
- R4: With `interleave`=0, beat n of a length-L burst is at column `(S & ~(L-1)) | ((S+n) & (L-1))`, where S is the starting column.
- R5: With `interleave`=1, beat n is at column `S ^ n`.
- R6: `len_code`=3'b111 with `interleave`=0 selects full page. The column rises by 1 each cycle and wraps from 255 to 0. `beat_last` is never set, and the burst runs until it is stopped or replaced.
- R7: The reserved codes 3'b100, 3'b101 and 3'b110, and 3'b111 with `interleave`=1, produce a single-beat burst.
- R8: `stop` high without `start` makes `beat_valid` 0 in the next cycle. When `start` and `stop` are high in the same cycle, `start` wins.
- R9: A `start` during a burst, on any beat, replaces that burst from the next cycle with the new starting column and mode.
- R10: With `single_write`=1, a start with `is_write`=1 gives a one-beat burst, and a start with `is_write`=0 uses the programmed length.
- R11: The mode inputs and `start_col` are sampled only with `start`. Changing them during a burst has no effect on its columns or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst (also replaces a running one) |
| stop | input | 1 | Terminate the running burst |
| is_write | input | 1 | The starting command is a write |
| start_col | input | 8 | Starting column |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 0 = sequential order, 1 = interleaved order |
| single_write | input | 1 | 1 = writes are single accesses |
| col_addr | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | Current beat is the final one |

## Verification
On every cycle, the assertions check the following:
- a start loads its column in the next cycle;
- a final beat or a stop drops the valid flag;
- a full-page burst steps by one with wrap;
- a single-mode write is one beat long;
- the last flag never appears without a valid beat.

Only the bench's scenarios can show the complete address order of each length in both orderings, the reserved-code handling, replacement on an arbitrary beat, and the fact that mode inputs changed mid-burst are ignored.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             single_write,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             beat_last
);

  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic             valid_q, ilv_q, full_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d;

  always_comb begin
    full_d = 1'b0;
    case (len_code)
      3'b001:  mask_d = COL_W'(1);
      3'b010:  mask_d = COL_W'(3);
      3'b011:  mask_d = COL_W'(7);
      3'b111: begin
        mask_d = interleave ? '0 : ALL_ONES;
        full_d = !interleave;
      end
      default: mask_d = '0;
    endcase
    if (is_write && single_write) begin
      mask_d = '0;
      full_d = 1'b0;
    end
  end

  assign beat_valid = valid_q;
  assign beat_last  = valid_q && !full_q && (cnt_q == mask_q);
  assign col_addr   = ilv_q ? (base_q ^ cnt_q)
                            : ((base_q & ~mask_q) | ((base_q + cnt_q) & mask_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      base_q  <= start_col;
      cnt_q   <= '0;
      mask_q  <= mask_d;
      full_q  <= full_d;
      ilv_q   <= interleave;
    end else if (stop) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (beat_last) valid_q <= 1'b0;
      else           cnt_q   <= cnt_q + 1'b1;
    end
  end

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> beat_valid && col_addr == $past(start_col));

  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !start) |=> !beat_valid);

  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && full_q && !start && !stop) |=> beat_valid && !beat_last && col_addr == $past(col_addr) + 1'b1);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !beat_valid);

  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_write && single_write) |=> beat_last);

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, is_write = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0, single_write = 1'b0;
  logic [7:0] col_addr;
  logic       beat_valid, beat_last;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .is_write(is_write),
    .start_col(start_col), .len_code(len_code), .interleave(interleave),
    .single_write(single_write), .col_addr(col_addr), .beat_valid(beat_valid),
    .beat_last(beat_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int n, input int len, input bit ilv);
    if (ilv) return (s ^ n) & 255;
    return ((s & ~(len - 1)) | ((s + n) & (len - 1))) & 255;
  endfunction

  task automatic issue(input logic [7:0] s, input logic [2:0] code, input logic ilv,
                       input logic wr, input logic sw);
    start_col = s; len_code = code; interleave = ilv; is_write = wr; single_write = sw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_burst(input int s, input int len, input bit ilv, input string req);
    for (int n = 0; n < len; n++) begin
      chk(beat_valid == 1'b1, req, beat_valid, 1);
      chk(col_addr == exp_col(s, n, len, ilv), req, col_addr, exp_col(s, n, len, ilv));
      chk(beat_last == (n == len - 1), req, beat_last, (n == len - 1));
      @(negedge clk);
    end
    chk(beat_valid == 1'b0, req, beat_valid, 0);
  endtask

  task automatic t_reset;
    chk(beat_valid == 1'b0 && beat_last == 1'b0, "R1 reset", {beat_valid, beat_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid == 1'b0 && beat_last == 1'b0, "R1 after reset", {beat_valid, beat_last}, 0);
  endtask

  task automatic t_seq;
    for (int c = 0; c < 4; c++) begin
      issue(8'h35, 3'(c), 1'b0, 1'b0, 1'b0);
      expect_burst(8'h35, 1 << c, 1'b0, "R2/R3/R4 sequential");
    end
    issue(8'hC2, 3'b011, 1'b0, 1'b0, 1'b0);
    expect_burst(8'hC2, 8, 1'b0, "R4 sequential aligned wrap");
  endtask

  task automatic t_ilv;
    issue(8'h5B, 3'b010, 1'b1, 1'b0, 1'b0);
    expect_burst(8'h5B, 4, 1'b1, "R5 interleaved 4");
    issue(8'h5B, 3'b011, 1'b1, 1'b0, 1'b0);
    expect_burst(8'h5B, 8, 1'b1, "R5 interleaved 8");
  endtask

  task automatic t_reserved;
    for (int c = 4; c < 7; c++) begin
      issue(8'h47, 3'(c), 1'b0, 1'b0, 1'b0);
      expect_burst(8'h47, 1, 1'b0, "R7 reserved code");
    end
    issue(8'h47, 3'b111, 1'b1, 1'b0, 1'b0);
    expect_burst(8'h47, 1, 1'b1, "R7 full page with interleave");
  endtask

  task automatic t_full;
    issue(8'hFD, 3'b111, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 6; n++) begin
      chk(beat_valid == 1'b1, "R6 full page valid", beat_valid, 1);
      chk(col_addr == 8'((8'hFD + n) % 256), "R6 full page wrap", col_addr, (8'hFD + n) % 256);
      chk(beat_last == 1'b0, "R6 full page no last", beat_last, 0);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(beat_valid == 1'b0, "R6/R8 full page stopped", beat_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_stop;
    issue(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
    chk(col_addr == 8'h10, "R8 beat0", col_addr, 8'h10);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(beat_valid == 1'b0 && beat_last == 1'b0, "R8 stop", {beat_valid, beat_last}, 0);
    @(negedge clk);
    chk(beat_valid == 1'b0, "R8 stays idle", beat_valid, 0);
  endtask

  task automatic t_interrupt;
    issue(8'h35, 3'b011, 1'b0, 1'b0, 1'b0);
    chk(col_addr == 8'h35, "R9 first burst beat0", col_addr, 8'h35);
    @(negedge clk);
    chk(col_addr == 8'h36, "R9 first burst beat1", col_addr, 8'h36);
    issue(8'h81, 3'b010, 1'b1, 1'b0, 1'b0);
    expect_burst(8'h81, 4, 1'b1, "R9 replaced burst");
    issue(8'h20, 3'b011, 1'b0, 1'b0, 1'b0);
    start_col = 8'h13; len_code = 3'b001; interleave = 1'b0;
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    expect_burst(8'h13, 2, 1'b0, "R8 start wins over stop");
  endtask

  task automatic t_single_write;
    issue(8'h64, 3'b010, 1'b0, 1'b1, 1'b1);
    expect_burst(8'h64, 1, 1'b0, "R10 single write");
    issue(8'h64, 3'b010, 1'b0, 1'b0, 1'b1);
    expect_burst(8'h64, 4, 1'b0, "R10 read keeps length");
    issue(8'h64, 3'b010, 1'b0, 1'b1, 1'b0);
    expect_burst(8'h64, 4, 1'b0, "R10 burst write");
  endtask

  task automatic t_mode_hold;
    issue(8'h35, 3'b011, 1'b0, 1'b0, 1'b0);
    start_col = 8'h00; len_code = 3'b000; interleave = 1'b1;
    is_write = 1'b1; single_write = 1'b1;
    expect_burst(8'h35, 8, 1'b0, "R11 mode sampled at start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_reserved();
    t_full();
    t_stop();
    t_interrupt();
    t_single_write();
    t_mode_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule